// File: doc/BRIEF.md
# Register Rename Map with Free List

This block gives each instruction's logical register specifiers their physical register tags. It suits a small out-of-order core. A mapping table, indexed by logical register number, holds the physical tag that currently carries each logical register's value. A first-in first-out list holds the physical tags that no instruction owns.

Each request carries two source specifiers and an optional destination specifier. The block answers in the same cycle with the physical tags of both sources, read before any update. When the request has a destination, the block also takes the oldest free tag from the list. That tag becomes the destination's new mapping at the clock edge. The block reports the tag it replaced so that commit logic can hand it back later. A separate release port returns tags to the tail of the list.

One instruction is renamed per cycle. When the list is empty the block withholds its ready signal, and no state changes. Physical tags outnumber logical registers. The spare tags form the free list at reset.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i from 0 to 7. The free list holds tags 8 to 15, and 8 is at its head. `rename_ready` is high. Logical specifiers are 3-bit binary and physical tags are 4-bit binary.
- R2: In every cycle, `src_a_ptag` and `src_b_ptag` equal the current mappings of `src_a_lreg` and `src_b_lreg`. They are combinational and do not depend on `req_valid`.
- R3: A request is accepted when `req_valid` and `rename_ready` are both high. If it has `req_has_dst` set, `new_ptag` is the head of the free list. From the next cycle on, `dst_lreg` maps to that tag, and that tag has left the list.
- R4: For an accepted request with a destination, `old_ptag` equals the mapping that `dst_lreg` held before the request.
- R5: When a source specifier equals the destination specifier, the source tag is the old mapping, not the newly allocated tag.
- R6: An accepted request with `req_has_dst` low leaves the mapping table and the free list unchanged. The next allocation gets the same head tag.
- R7: When `rel_valid` is high, `rel_ptag` is appended at the tail of the free list. Tags are handed out in the order in which they entered the list.
- R8: A release and an allocation in the same cycle both take effect. The allocation takes the old head, and the released tag goes to the tail.
- R9: When the free list is empty, `rename_ready` is low, and a request changes neither the table nor the list. A release in that cycle raises `rename_ready` in the next cycle. It does not serve the same-cycle request.
- R10: An allocated tag never equals the old mapping it replaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A rename request is present |
| src_a_lreg | input | 3 | First source logical register |
| src_b_lreg | input | 3 | Second source logical register |
| req_has_dst | input | 1 | The request writes a destination |
| dst_lreg | input | 3 | Destination logical register |
| rename_ready | output | 1 | The free list is not empty, so a request can be accepted |
| src_a_ptag | output | 4 | Physical tag of the first source |
| src_b_ptag | output | 4 | Physical tag of the second source |
| new_ptag | output | 4 | Tag allocated to the destination (head of the free list) |
| old_ptag | output | 4 | Previous mapping of the destination |
| rel_valid | input | 1 | Return a tag to the free list |
| rel_ptag | input | 4 | Tag being returned |

## Verification
The assertions take two things for granted about the inputs. First, a released tag is one that the block itself displaced earlier and has not been released yet. Second, a release is never offered when the list already holds every spare tag. Under these conditions the list cannot overflow, and a new tag can never collide with a live mapping.

The stimulus stays within these limits. It releases only tags that it collected from `old_ptag` on accepted renames, and it releases each of them once. Because tags are conserved, the free list can never be more than full. Directed phases drain the list to empty, stall on it, and refill it with simultaneous releases and allocations. A long random phase follows, and a behavioural queue model checks it every cycle.

// File: rtl/ren_pkg.sv
// Package: default sizes shared by the rename block and its bench.
// Assumes: physical registers outnumber logical registers.
package ren_pkg;
    localparam int unsigned REN_LOG_REGS  = 8;
    localparam int unsigned REN_PHYS_REGS = 16;

    // Free-list operation in one cycle, used for readable case decoding.
    typedef enum logic [1:0] {
        FL_IDLE = 2'b00,
        FL_POP  = 2'b01,
        FL_PUSH = 2'b10,
        FL_BOTH = 2'b11
    } fl_op_e;
endpackage

// File: rtl/ren_map_table.sv
// Module: ren_map_table
// Holds one physical tag per logical register and has three
// combinational read ports: two sources and the destination's old value.
// It has one synchronous write port.
// Assumes: at most one write per cycle. Reads return pre-write values.
module ren_map_table #(
    parameter int unsigned NLOG = 8,
    parameter int unsigned PW   = 4,
    localparam int unsigned LW  = (NLOG > 1) ? $clog2(NLOG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_a_idx,
    input  logic [LW-1:0] rd_b_idx,
    input  logic [LW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a_tag,
    output logic [PW-1:0] rd_b_tag,
    output logic [PW-1:0] rd_d_tag,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [PW-1:0] wr_tag
);
    logic [PW-1:0] table_q [NLOG];

    // Identity mapping on reset, single-entry update otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NLOG); i++) begin
                table_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_tag;
        end
    end

    // Source and destination lookups, before this cycle's write.
    always_comb begin
        rd_a_tag = table_q[rd_a_idx];
        rd_b_tag = table_q[rd_b_idx];
        rd_d_tag = table_q[rd_d_idx];
    end

    // A write is visible at its index in the following cycle.
    assert_map_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> table_q[$past(wr_idx)] == $past(wr_tag));

    // An entry that is not written keeps its value.
    assert_map_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_d_tag) || !$stable(rd_d_idx));
endmodule

// File: rtl/ren_free_fifo.sv
// Module: ren_free_fifo
// A circular first-in first-out list of unallocated physical tags. At
// reset it is full of tags NLOG .. NPHYS-1 in ascending order.
// Assumes: no pop when empty, and no push when full unless a pop occurs
// in the same cycle.
module ren_free_fifo
    import ren_pkg::*;
#(
    parameter int unsigned NLOG  = 8,
    parameter int unsigned NPHYS = 16,
    parameter int unsigned PW    = 4,
    localparam int unsigned DEPTH = NPHYS - NLOG,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_tag,
    output logic [PW-1:0] head_tag,
    output logic          empty
);
    logic [PW-1:0] slot_q [DEPTH];
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] count_q;
    logic          full;
    fl_op_e        op;

    // Pointer advance with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decode the cycle's operation.
    always_comb begin
        op       = fl_op_e'({push, pop});
        empty    = (count_q == '0);
        full     = (count_q == CW'(DEPTH));
        head_tag = slot_q[rd_ptr_q];
    end

    // Slot storage: preload spare tags on reset, write at tail on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                slot_q[i] <= PW'(int'(NLOG) + i);
            end
        end else if (push) begin
            slot_q[wr_ptr_q] <= push_tag;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= CW'(DEPTH);
        end else begin
            case (op)
                FL_POP: begin
                    rd_ptr_q <= bump(rd_ptr_q);
                    count_q  <= count_q - 1'b1;
                end
                FL_PUSH: begin
                    wr_ptr_q <= bump(wr_ptr_q);
                    count_q  <= count_q + 1'b1;
                end
                FL_BOTH: begin
                    rd_ptr_q <= bump(rd_ptr_q);
                    wr_ptr_q <= bump(wr_ptr_q);
                end
                default: ;
            endcase
        end
    end

    // Allocation only from a non-empty list.
    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // A release never overflows the list.
    assert_push_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // Pushing onto an empty list makes its tag the next head.
    assert_push_to_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && empty) |=> head_tag == $past(push_tag));
endmodule

// File: rtl/rename_unit.sv
// Module: rename_unit
// Renames one instruction per cycle. Source tags come from the mapping
// table before the update. A destination takes the free-list head and
// reports the tag it displaced. The release port refills the list.
// Assumes: released tags are previously displaced tags, each freed once.
module rename_unit
    import ren_pkg::*;
#(
    parameter int unsigned NLOG  = REN_LOG_REGS,
    parameter int unsigned NPHYS = REN_PHYS_REGS,
    localparam int unsigned LW   = (NLOG > 1) ? $clog2(NLOG) : 1,
    localparam int unsigned PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [LW-1:0] src_a_lreg,
    input  logic [LW-1:0] src_b_lreg,
    input  logic          req_has_dst,
    input  logic [LW-1:0] dst_lreg,
    output logic          rename_ready,
    output logic [PW-1:0] src_a_ptag,
    output logic [PW-1:0] src_b_ptag,
    output logic [PW-1:0] new_ptag,
    output logic [PW-1:0] old_ptag,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_ptag
);
    logic fl_empty;
    logic accept;
    logic alloc;

    // Accept and allocate decisions for this cycle.
    always_comb begin
        rename_ready = !fl_empty;
        accept       = req_valid && rename_ready;
        alloc        = accept && req_has_dst;
    end

    ren_map_table #(.NLOG(NLOG), .PW(PW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a_lreg),
        .rd_b_idx (src_b_lreg),
        .rd_d_idx (dst_lreg),
        .rd_a_tag (src_a_ptag),
        .rd_b_tag (src_b_ptag),
        .rd_d_tag (old_ptag),
        .wr_en    (alloc),
        .wr_idx   (dst_lreg),
        .wr_tag   (new_ptag)
    );

    ren_free_fifo #(.NLOG(NLOG), .NPHYS(NPHYS), .PW(PW)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_tag (rel_ptag),
        .head_tag (new_ptag),
        .empty    (fl_empty)
    );

    // A fresh tag never aliases the mapping it replaces.
    assert_fresh_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> new_ptag != old_ptag);

    // With nothing released, a stall keeps the block stalled.
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_ready && !rel_valid) |=> !rename_ready);

    // A source read of the destination sees the displaced tag.
    assert_src_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && src_a_lreg == dst_lreg) |-> src_a_ptag == old_ptag);
endmodule

// File: tb/sim_rename_unit.sv
// Bench for rename_unit: a behavioural queue model, compared every cycle.
module sim_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] src_a_lreg = '0, src_b_lreg = '0, dst_lreg = '0;
    logic       req_has_dst = 1'b0;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_ptag = '0;
    logic       rename_ready;
    logic [3:0] src_a_ptag, src_b_ptag, new_ptag, old_ptag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int model_map [8];
    int model_free [$];
    int pend [$];

    always #5 clk = ~clk;

    rename_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .src_a_lreg(src_a_lreg), .src_b_lreg(src_b_lreg),
        .req_has_dst(req_has_dst), .dst_lreg(dst_lreg),
        .rename_ready(rename_ready), .src_a_ptag(src_a_ptag),
        .src_b_ptag(src_b_ptag), .new_ptag(new_ptag), .old_ptag(old_ptag),
        .rel_valid(rel_valid), .rel_ptag(rel_ptag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare against the model mid-cycle, update the model.
    task automatic step(input string ctx, input bit v, input int a, input int b,
                        input bit hd, input int d, input bit rel);
        bit fire;
        int exp_new;
        int exp_old;
        @(posedge clk);
        #1;
        req_valid   = v;
        src_a_lreg  = 3'(a);
        src_b_lreg  = 3'(b);
        req_has_dst = hd;
        dst_lreg    = 3'(d);
        rel_valid   = rel && (pend.size() > 0);
        rel_ptag    = (pend.size() > 0) ? 4'(pend[0]) : 4'd0;
        #3;
        fire = v && (model_free.size() > 0);
        check({ctx, "/R9"}, "rename_ready", int'(rename_ready), int'(model_free.size() > 0));
        check({ctx, ((hd && a == d) ? "/R5" : "/R2")}, "src_a_ptag", int'(src_a_ptag), model_map[a]);
        check({ctx, ((hd && b == d) ? "/R5" : "/R2")}, "src_b_ptag", int'(src_b_ptag), model_map[b]);
        if (fire && hd) begin
            exp_new = model_free[0];
            exp_old = model_map[d];
            check({ctx, "/R3"}, "new_ptag", int'(new_ptag), exp_new);
            check({ctx, "/R4"}, "old_ptag", int'(old_ptag), exp_old);
            check({ctx, "/R10"}, "new_vs_old", int'(new_ptag != old_ptag), 1);
            void'(model_free.pop_front());
            model_map[d] = exp_new;
            pend.push_back(exp_old);
        end
        if (rel_valid) begin
            model_free.push_back(pend[0]);
            void'(pend.pop_front());
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model_map[i] = i;
        for (int i = 8; i < 16; i++) model_free.push_back(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset mapping read through the source ports, ready high.
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            #1;
            src_a_lreg = 3'(i);
            src_b_lreg = 3'(7 - i);
            #3;
            check("R1", "reset map a", int'(src_a_ptag), i);
            check("R1", "reset map b", int'(src_b_ptag), 7 - i);
            check("R1", "reset ready", int'(rename_ready), 1);
            if (i == 0) check("R1", "reset head", int'(new_ptag), 8);
        end

        // R5: r3 <- r3 sees old tag 3, gets tag 8.
        step("R5", 1, 3, 3, 1, 3, 0);
        check("R5", "old mapping of r3", int'(old_ptag), 3);
        check("R5", "new tag for r3", int'(new_ptag), 8);

        // R6: a request without destination does not consume the head (9).
        step("R6", 1, 1, 2, 0, 4, 0);
        step("R6", 1, 0, 0, 1, 5, 0);
        check("R6", "head unchanged", int'(new_ptag), 9);

        // R3: drain the list.
        for (int k = 0; k < 6; k++) step("R3", 1, k, 7, 1, k, 0);

        // R9: empty -> stalled, no state change.
        step("R9", 1, 5, 3, 1, 5, 0);
        check("R9", "ready low when empty", int'(rename_ready), 0);
        step("R9", 1, 5, 3, 1, 5, 0);
        check("R9", "r5 still mapped", int'(src_a_ptag), model_map[5]);

        // R9/R8: release while empty does not serve same-cycle request.
        step("R9", 1, 2, 2, 1, 2, 1);
        check("R9", "no bypass of release", int'(rename_ready), 0);

        // R7: the released tag (3, displaced first) is handed out next.
        step("R7", 1, 1, 1, 1, 1, 0);
        check("R7", "released tag reissued", int'(new_ptag), 3);

        // R8: refill one, then release and allocate together.
        step("R8", 0, 0, 0, 0, 0, 1);
        step("R8", 1, 6, 6, 1, 6, 1);
        check("R8", "alloc with release", int'(rename_ready), 1);
        step("R8", 1, 4, 4, 1, 4, 0);
        check("R8", "released tag queued", int'(rename_ready), 1);

        // Random phase, model checked every cycle.
        for (int n = 0; n < 600; n++) begin
            step("rand", ($urandom % 5) != 0, int'($urandom % 8), int'($urandom % 8),
                 ($urandom % 4) != 0, int'($urandom % 8), ($urandom % 5) < 2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule